// File: doc/BRIEF.md
# Four-Bit Function-Select ALU Slice with Cascade

This block is a purely combinational arithmetic logic unit built from four-bit slices. Each slice takes two operands, a four-bit function code, a mode bit and a carry input. In logic mode the code picks one of the sixteen two-input Boolean functions, applied bit by bit. In arithmetic mode the code picks one of sixteen sums. Each sum adds two operand-derived words and the carry input.

Every slice also reports its group propagate and group generate terms and an all-ones flag. An external lookahead unit can use these terms to produce carries across slices. The top module chains a parameterised number of slices. Carries ripple from each slice to the next, and a second lookahead stage combines the slice terms into word-level group terms.

Per bit, the slice forms two words from A, B and the code: a first word X = A | (B & s[0]) | (~B & s[1]) and a second word Y = A & ((B & s[3]) | (~B & s[2])). Y is never set where X is clear. These two words drive every requirement below.

Top module: `alu4_cascade`

## Requirements
- R1: With logic_mode = 1 (0 selects arithmetic), each result bit depends only on the matching operand bits. The codes give: 0000 ~A, 0001 ~(A|B), 0010 ~A&B, 0011 constant 0, 0100 ~(A&B), 0101 ~B, 0110 A^B, 0111 A&~B, 1000 ~A|B, 1001 ~(A^B), 1010 B, 1011 A&B, 1100 constant 1, 1101 A|~B, 1110 A|B, 1111 A.
- R2: In logic mode, carry_in has no effect on result.
- R3: In arithmetic mode, result is the low bits of X + Y + carry_in. The (X, Y) pairs per code are: 0000 (A,0), 0001 (A|B,0), 0010 (A|~B,0), 0011 (all ones,0), 0100 (A,A&~B), 0101 (A|B,A&~B), 0110 (A|~B,A&~B), 0111 (all ones,A&~B), 1000 (A,A&B), 1001 (A|B,A&B), 1010 (A|~B,A&B), 1011 (all ones,A&B), 1100 (A,A), 1101 (A|B,A), 1110 (A|~B,A), 1111 (all ones,A). Code 1001 therefore gives A+B+carry_in, and code 0110 with carry_in = 1 gives A−B.
- R4: In arithmetic mode, carry_out is the bit just above the result in that sum. For code 0110 with carry_in = 1, carry_out = 1 means no borrow.
- R5: operands_equal is high exactly when every result bit is one. With code 0110, arithmetic mode and carry_in = 0, this is high exactly when A equals B.
- R6: grp_prop is high exactly when every bit of X is one. grp_gen is the carry out of X + Y with a zero carry in. In both modes, carry_out = grp_gen | (grp_prop & carry_in).
- R7: With two slices, slice 0 holds the least significant bits. The 8-bit result and carry_out match R1 and R3/R4 applied to the full 8-bit operands.
- R8: With two slices, the word-level grp_prop, grp_gen and operands_equal follow R5 and R6 over the full 8-bit word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | SLICES*SLICE_W | First operand |
| op_b | input | SLICES*SLICE_W | Second operand |
| func_sel | input | 4 | Function code |
| logic_mode | input | 1 | 1 = bitwise Boolean, 0 = arithmetic |
| carry_in | input | 1 | Carry into the least significant slice |
| result | output | SLICES*SLICE_W | Function result |
| carry_out | output | 1 | Carry out of the most significant slice |
| operands_equal | output | 1 | High when result is all ones |
| grp_prop | output | 1 | Word group propagate |
| grp_gen | output | 1 | Word group generate |

## Verification
The block holds no state, so a faulty internal term shows up at the ports in the same cycle as the input that exposes it. A wrong X or Y bit corrupts the logic-mode result for the affected code. In arithmetic mode it also spreads through the carries into the higher result bits, carry_out and the group terms. A broken lookahead prefix shows only for operand patterns that carry across that bit. An exhaustive sweep of one slice covers every code, mode and carry against every operand pair. Random sweeps of the two-slice word then expose any fault in the carry that passes between slices.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

   localparam int unsigned SEL_W = 4;

   typedef logic [SEL_W-1:0] opsel_t;

   typedef struct packed {
      logic prop;
      logic gen;
   } bit_terms_t;

   // Per-bit first-word (prop) and second-word (gen) terms for one bit pair.
   function automatic bit_terms_t make_terms(input logic a, input logic b, input opsel_t sel);
      bit_terms_t t;
      t.prop = a | (b & sel[0]) | (~b & sel[1]);
      t.gen  = a & ((b & sel[3]) | (~b & sel[2]));
      return t;
   endfunction

endpackage

// File: rtl/alu4_terms.sv
module alu4_terms
   import alu4_pkg::*;
#(
   parameter int unsigned W = 4
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  opsel_t       sel,
   output logic [W-1:0] prop,
   output logic [W-1:0] gen
);

   if (W < 1) begin : g_bad_width
      $error("alu4_terms: W must be at least 1");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      bit_terms_t t;
      assign t       = make_terms(a[i], b[i], sel);
      assign prop[i] = t.prop;
      assign gen[i]  = t.gen;
   end

   always_comb begin
      AST_GEN_WITHIN_PROP: assert ((gen & ~prop) == '0) else $error("generate outside propagate"); // R6
   end

endmodule

// File: rtl/alu4_lookahead.sv
module alu4_lookahead #(
   parameter int unsigned W = 4
) (
   input  logic [W-1:0] prop,
   input  logic [W-1:0] gen,
   input  logic         cin,
   output logic [W-1:0] carry_into,
   output logic         grp_prop,
   output logic         grp_gen,
   output logic         cout
);

   if (W < 1) begin : g_bad_width
      $error("alu4_lookahead: W must be at least 1");
   end

   always_comb begin
      logic pacc;
      logic gacc;
      pacc = 1'b1;
      gacc = 1'b0;
      for (int i = 0; i < W; i++) begin
         carry_into[i] = gacc | (pacc & cin);
         gacc          = gen[i] | (prop[i] & gacc);
         pacc          = pacc & prop[i];
      end
      grp_prop = pacc;
      grp_gen  = gacc;
      cout     = gacc | (pacc & cin);
   end

endmodule

// File: rtl/alu4_slice.sv
module alu4_slice
   import alu4_pkg::*;
#(
   parameter int unsigned W = 4
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  opsel_t       sel,
   input  logic         logic_mode,
   input  logic         cin,
   output logic [W-1:0] result,
   output logic         cout,
   output logic         equal,
   output logic         grp_prop,
   output logic         grp_gen
);

   localparam opsel_t SUB_CODE = 4'b0110;

   logic [W-1:0] prop;
   logic [W-1:0] gen;
   logic [W-1:0] carry_into;

   alu4_terms #(.W(W)) u_terms (
      .a    (a),
      .b    (b),
      .sel  (sel),
      .prop (prop),
      .gen  (gen)
   );

   alu4_lookahead #(.W(W)) u_la (
      .prop       (prop),
      .gen        (gen),
      .cin        (cin),
      .carry_into (carry_into),
      .grp_prop   (grp_prop),
      .grp_gen    (grp_gen),
      .cout       (cout)
   );

   // Because gen never exceeds prop, prop ^ gen reduces to prop & ~gen.
   assign result = logic_mode ? (~prop | gen) : ((prop & ~gen) ^ carry_into);
   assign equal  = &result;

   always_comb begin
      if (!logic_mode) begin
         AST_ARITH_SUM: assert ({cout, result} == ({1'b0, prop} + {1'b0, gen} + {{W{1'b0}}, cin})) else $error("sum mismatch"); // R3
      end
      if (!logic_mode && (sel == SUB_CODE) && !cin) begin
         AST_SUB_EQUAL: assert (equal == (a == b)) else $error("equality flag wrong"); // R5
      end
   end

endmodule

// File: rtl/alu4_cascade.sv
module alu4_cascade
   import alu4_pkg::*;
#(
   parameter  int unsigned SLICES  = 2,
   parameter  int unsigned SLICE_W = 4,
   localparam int unsigned WORD_W  = SLICES * SLICE_W
) (
   input  logic [WORD_W-1:0] op_a,
   input  logic [WORD_W-1:0] op_b,
   input  logic [3:0]        func_sel,
   input  logic              logic_mode,
   input  logic              carry_in,
   output logic [WORD_W-1:0] result,
   output logic              carry_out,
   output logic              operands_equal,
   output logic              grp_prop,
   output logic              grp_gen
);

   if (SLICES < 1) begin : g_bad_slices
      $error("alu4_cascade: SLICES must be at least 1");
   end

   logic [SLICES-1:0] s_cin;
   logic [SLICES-1:0] s_cout;
   logic [SLICES-1:0] s_eq;
   logic [SLICES-1:0] s_p;
   logic [SLICES-1:0] s_g;

   for (genvar k = 0; k < SLICES; k++) begin : g_slice
      if (k == 0) begin : g_first
         assign s_cin[k] = carry_in;
      end else begin : g_next
         assign s_cin[k] = s_cout[k-1];
      end

      alu4_slice #(.W(SLICE_W)) u_slice (
         .a          (op_a[k*SLICE_W +: SLICE_W]),
         .b          (op_b[k*SLICE_W +: SLICE_W]),
         .sel        (opsel_t'(func_sel)),
         .logic_mode (logic_mode),
         .cin        (s_cin[k]),
         .result     (result[k*SLICE_W +: SLICE_W]),
         .cout       (s_cout[k]),
         .equal      (s_eq[k]),
         .grp_prop   (s_p[k]),
         .grp_gen    (s_g[k])
      );
   end

   assign carry_out      = s_cout[SLICES-1];
   assign operands_equal = &s_eq;

   if (SLICES == 1) begin : g_single
      assign grp_prop = s_p[0];
      assign grp_gen  = s_g[0];
   end else begin : g_multi
      logic [SLICES-1:0] la_cin;
      logic              la_cout;

      alu4_lookahead #(.W(SLICES)) u_word_la (
         .prop       (s_p),
         .gen        (s_g),
         .cin        (carry_in),
         .carry_into (la_cin),
         .grp_prop   (grp_prop),
         .grp_gen    (grp_gen),
         .cout       (la_cout)
      );

      always_comb begin
         AST_RIPPLE_MATCH: assert ((la_cin == s_cin) && (la_cout == carry_out)) else $error("ripple and lookahead disagree"); // R7
      end
   end

endmodule

// File: tb/alu4_cascade_test.sv
module alu4_cascade_test;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   int  checks = 0;
   int  fails  = 0;
   bit  done   = 1'b0;

   logic [3:0] a1, b1, sel1;
   logic       m1, c1;
   logic [3:0] r1;
   logic       co1, eq1, p1, g1;

   logic [7:0] a2, b2;
   logic [3:0] sel2;
   logic       m2, c2;
   logic [7:0] r2;
   logic       co2, eq2, p2, g2;

   alu4_cascade #(.SLICES(1)) uut_one (
      .op_a(a1), .op_b(b1), .func_sel(sel1), .logic_mode(m1), .carry_in(c1),
      .result(r1), .carry_out(co1), .operands_equal(eq1), .grp_prop(p1), .grp_gen(g1)
   );

   alu4_cascade uut (
      .op_a(a2), .op_b(b2), .func_sel(sel2), .logic_mode(m2), .carry_in(c2),
      .result(r2), .carry_out(co2), .operands_equal(eq2), .grp_prop(p2), .grp_gen(g2)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // R3 operand pairs.
   function automatic void operand_pair(input logic [3:0] s, input logic [7:0] a, input logic [7:0] b,
                                        output logic [7:0] x, output logic [7:0] y);
      case (s)
         4'h0: begin x = a;      y = 8'h00;  end
         4'h1: begin x = a | b;  y = 8'h00;  end
         4'h2: begin x = a | ~b; y = 8'h00;  end
         4'h3: begin x = 8'hFF;  y = 8'h00;  end
         4'h4: begin x = a;      y = a & ~b; end
         4'h5: begin x = a | b;  y = a & ~b; end
         4'h6: begin x = a | ~b; y = a & ~b; end
         4'h7: begin x = 8'hFF;  y = a & ~b; end
         4'h8: begin x = a;      y = a & b;  end
         4'h9: begin x = a | b;  y = a & b;  end
         4'hA: begin x = a | ~b; y = a & b;  end
         4'hB: begin x = 8'hFF;  y = a & b;  end
         4'hC: begin x = a;      y = a;      end
         4'hD: begin x = a | b;  y = a;      end
         4'hE: begin x = a | ~b; y = a;      end
         default: begin x = 8'hFF; y = a;    end
      endcase
   endfunction

   // R1 Boolean table.
   function automatic logic [7:0] logic_ref(input logic [3:0] s, input logic [7:0] a, input logic [7:0] b);
      case (s)
         4'h0: return ~a;
         4'h1: return ~(a | b);
         4'h2: return ~a & b;
         4'h3: return 8'h00;
         4'h4: return ~(a & b);
         4'h5: return ~b;
         4'h6: return a ^ b;
         4'h7: return a & ~b;
         4'h8: return ~a | b;
         4'h9: return ~(a ^ b);
         4'hA: return b;
         4'hB: return a & b;
         4'hC: return 8'hFF;
         4'hD: return a | ~b;
         4'hE: return a | b;
         default: return a;
      endcase
   endfunction

   task automatic run_vec(input bit wide, input int s, input int m, input int c, input int a, input int b);
      logic [7:0] x, y, mask;
      int w, sum, exp_res, exp_cout, exp_p, exp_g, exp_eq;
      int act_res, act_cout, act_eq, act_p, act_g;
      @(posedge clk);
      if (wide) begin
         a2 = 8'(a); b2 = 8'(b); sel2 = 4'(s); m2 = 1'(m); c2 = 1'(c);
      end else begin
         a1 = 4'(a); b1 = 4'(b); sel1 = 4'(s); m1 = 1'(m); c1 = 1'(c);
      end
      @(negedge clk);
      w    = wide ? 8 : 4;
      mask = wide ? 8'hFF : 8'h0F;
      operand_pair(4'(s), 8'(a), 8'(b), x, y);
      x = x & mask;
      y = y & mask;
      exp_g = ((int'(x) + int'(y)) >> w) & 1;
      exp_p = (x == mask) ? 1 : 0;
      if (m != 0) begin
         exp_res  = int'(logic_ref(4'(s), 8'(a), 8'(b)) & mask);
         exp_cout = exp_g | (exp_p & c);
      end else begin
         sum      = int'(x) + int'(y) + c;
         exp_res  = sum & int'(mask);
         exp_cout = (sum >> w) & 1;
      end
      exp_eq = (exp_res == int'(mask)) ? 1 : 0;
      if (wide) begin
         act_res = int'(r2); act_cout = int'(co2); act_eq = int'(eq2); act_p = int'(p2); act_g = int'(g2);
         check("R7", "word result", act_res, exp_res);
         check("R7", "word carry_out", act_cout, exp_cout);
         check("R8", "word operands_equal", act_eq, exp_eq);
         check("R8", "word grp_prop", act_p, exp_p);
         check("R8", "word grp_gen", act_g, exp_g);
      end else begin
         act_res = int'(r1); act_cout = int'(co1); act_eq = int'(eq1); act_p = int'(p1); act_g = int'(g1);
         check(m != 0 ? "R1 R2" : "R3", "result", act_res, exp_res);
         check(m != 0 ? "R6" : "R4", "carry_out", act_cout, exp_cout);
         check("R5", "operands_equal", act_eq, exp_eq);
         check("R6", "grp_prop", act_p, exp_p);
         check("R6", "grp_gen", act_g, exp_g);
      end
   endtask

   initial begin
      a1 = '0; b1 = '0; sel1 = '0; m1 = 1'b0; c1 = 1'b0;
      a2 = '0; b2 = '0; sel2 = '0; m2 = 1'b0; c2 = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      // Quiet inputs: arithmetic code 0000 passes A = 0.
      check("R3", "idle result", int'(r1), 0);
      check("R4", "idle carry_out", int'(co1), 0);
      check("R5", "idle operands_equal", int'(eq1), 0);

      // Directed: 7 - 5 with carry in gives 2, no borrow.
      @(posedge clk); a1 = 4'd7; b1 = 4'd5; sel1 = 4'b0110; m1 = 1'b0; c1 = 1'b1;
      @(negedge clk);
      check("R3", "subtract 7-5", int'(r1), 2);
      check("R4", "subtract no borrow", int'(co1), 1);
      // Directed: 9 + 8 + 1 wraps to 2 with carry.
      @(posedge clk); a1 = 4'd9; b1 = 4'd8; sel1 = 4'b1001; c1 = 1'b1;
      @(negedge clk);
      check("R3", "add 9+8+1", int'(r1), 2);
      check("R4", "add carry", int'(co1), 1);
      // Directed: equal operands under subtract without carry.
      @(posedge clk); a1 = 4'd6; b1 = 4'd6; sel1 = 4'b0110; c1 = 1'b0;
      @(negedge clk);
      check("R5", "equal 6,6", int'(eq1), 1);
      // Directed: logic XOR ignores carry.
      @(posedge clk); a1 = 4'b1100; b1 = 4'b1010; sel1 = 4'b0110; m1 = 1'b1; c1 = 1'b1;
      @(negedge clk);
      check("R2", "xor with carry_in 1", int'(r1), 6);
      // Directed 8-bit: 42 - 23 = 19.
      @(posedge clk); a2 = 8'd42; b2 = 8'd23; sel2 = 4'b0110; m2 = 1'b0; c2 = 1'b1;
      @(negedge clk);
      check("R7", "word 42-23", int'(r2), 19);
      check("R7", "word no borrow", int'(co2), 1);

      // Exhaustive single-slice sweep.
      for (int s = 0; s < 16; s++)
         for (int m = 0; m < 2; m++)
            for (int c = 0; c < 2; c++)
               for (int a = 0; a < 16; a++)
                  for (int b = 0; b < 16; b++)
                     run_vec(1'b0, s, m, c, a, b);

      // Random two-slice sweep with fixed extremes.
      for (int n = 0; n < 200; n++) begin
         int ra, rb;
         ra = (n == 0) ? 255 : int'(8'($urandom));
         rb = (n == 0) ? 1   : int'(8'($urandom));
         for (int s = 0; s < 16; s++)
            for (int m = 0; m < 2; m++)
               for (int c = 0; c < 2; c++)
                  run_vec(1'b1, s, m, c, ra, rb);
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL R7 watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

endmodule